// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Conditions

This block is a register-mapped general-purpose pin controller for up to 32 pins. Software reaches it through a simple single-cycle port: a byte address, a write strobe, write data and combinational read data. The block holds 32-bit registers at 4-byte spacing, with one bit per pin. For each pin, software sets whether the pin is sampled, whether it is driven, the value it drives and an inversion applied to that value.

Every sampled pin passes through a two-flop synchronizer. Behind the synchronizer, four condition detectors watch the pin: a rising edge, a falling edge, a high level and a low level. Each condition latches into its own sticky pending bit, and software clears a pending bit by writing a one to its position. Each condition also has its own enable bit. Every pin drives its own interrupt line toward an external interrupt controller. That line is high while any enabled condition of the pin is pending.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pin_out`, `pin_oe` and `pin_irq` are 0, and no pending bit is set.
- R2: `pin_out` equals the output-value register (offset 0x0C) XOR the output-inversion register (offset 0x40), bit by bit. `pin_oe` equals the output-enable register (offset 0x08).
- R3: Reading offset 0x0C returns the last value written there, whatever the pin levels are.
- R4: Reading offset 0x00 returns the pin levels after a two-flop synchronizer, ANDed with the input-enable register (offset 0x04). A pin change applied between clock edges is visible after the second rising edge.
- R5: Each pin has four conditions, computed on the synchronized level `s` and its value one cycle earlier `p`. Rise is `s & ~p`, with pending at 0x1C. Fall is `~s & p`, with pending at 0x24. High is `s`, with pending at 0x2C. Low is `~s`, with pending at 0x34. A pending bit is set one clock after its condition is seen, which is the third rising edge after a pin change.
- R6: `pin_irq[i]` is the OR over the four conditions of (pending AND enable) for pin i. The enable registers are at 0x18 (rise), 0x20 (fall), 0x28 (high) and 0x30 (low). Each pin has its own line.
- R7: While a pin's input-enable bit is 0, none of its pending bits becomes set, and its input value reads 0.
- R8: A pending bit is set when its condition occurs, even if that condition's enable bit is 0.
- R9: A pending bit stays set after its condition has gone away, until software clears it.
- R10: Writing a pending register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R11: If a condition sets a pending bit in the same cycle as a write-one clear of that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | N_PINS | Raw pin levels, asynchronous |
| pin_out | output | N_PINS | Driven pin values |
| pin_oe | output | N_PINS | Pin drive enables |
| pin_irq | output | N_PINS | Interrupt line per pin |

## Verification
The hardest situation to reach from the ports is a hardware set and a software clear landing on the same pending bit in the same cycle. An edge lasts only one cycle and sits behind three register stages. Level conditions, however, re-assert on every cycle. The bench therefore holds every pin low with input enable on and writes all ones to the low-level pending register. Each bit then meets a clear and a set together, and it must read back as 1. Clearing a high-level pending bit after its pin has dropped shows the contrasting case, where the clear takes effect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 7;
  localparam int N_EV   = 4;

  typedef enum logic [1:0] {
    EV_RISE = 2'd0,
    EV_FALL = 2'd1,
    EV_HIGH = 2'd2,
    EV_LOW  = 2'd3
  } ev_kind_e;

  localparam logic [ADDR_W-1:0] A_IN_VAL  = 7'h00;
  localparam logic [ADDR_W-1:0] A_IN_EN   = 7'h04;
  localparam logic [ADDR_W-1:0] A_OUT_EN  = 7'h08;
  localparam logic [ADDR_W-1:0] A_OUT_VAL = 7'h0C;
  localparam logic [ADDR_W-1:0] A_OUT_XOR = 7'h40;

  // enable/pending pairs sit 8 bytes apart, rise first
  function automatic logic [ADDR_W-1:0] ev_en_addr(input int k);
    return ADDR_W'(32'h18 + 8 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] ev_pend_addr(input int k);
    return ADDR_W'(32'h1C + 8 * k);
  endfunction

  // one condition for one pin: cur = synchronized level, old = one cycle earlier
  function automatic logic ev_hit(input int k, input logic cur, input logic old);
    case (k)
      0:       return cur & ~old;
      1:       return ~cur & old;
      2:       return cur;
      default: return ~cur;
    endcase
  endfunction

  function automatic logic drive_bit(input logic val, input logic inv);
    return val ^ inv;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] en,
  output logic [N-1:0] level
);
  logic [N-1:0] meta_q;
  logic [N-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= raw;
      stab_q <= meta_q;
    end
  end

  assign level = stab_q & en;
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             level,
  input  logic [N-1:0]             in_en,
  input  logic [N_EV-1:0][N-1:0]   ev_en,
  input  logic [N_EV-1:0][N-1:0]   clr,
  output logic [N_EV-1:0][N-1:0]   pend,
  output logic [N_EV-1:0][N-1:0]   hit,
  output logic [N-1:0]             level_q,
  output logic [N-1:0]             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level;
  end

  for (genvar k = 0; k < N_EV; k++) begin : g_ev
    for (genvar p = 0; p < N; p++) begin : g_pin
      assign hit[k][p] = in_en[p] & ev_hit(k, level[p], level_q[p]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pend[k] <= '0;
      else        pend[k] <= (pend[k] & ~clr[k]) | hit[k];
    end

    // R9: a bit not being cleared keeps its value
    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend[k] & $past(pend[k] & ~clr[k])) == $past(pend[k] & ~clr[k])));

    // R11: a detected condition always lands, even against a clear
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend[k] & $past(hit[k])) == $past(hit[k])));
  end

  always_comb begin
    irq = '0;
    for (int k = 0; k < N_EV; k++) irq = irq | (pend[k] & ev_en[k]);
  end

  // R5: a freshly set rise bit means the previous synchronized level was 1
  assert_rise_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend[EV_RISE] & ~$past(pend[EV_RISE])) & ~level_q) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_irq
);
  localparam int N = N_PINS;

  logic [N-1:0] in_en, out_en, out_val, out_xor;
  logic [N_EV-1:0][N-1:0] ev_en, clr, pend, hit;
  logic [N-1:0] level, level_q;
  logic [N-1:0] rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_en   <= '0;
      out_en  <= '0;
      out_val <= '0;
      out_xor <= '0;
      ev_en   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_IN_EN:   in_en   <= bus_wdata[N-1:0];
        A_OUT_EN:  out_en  <= bus_wdata[N-1:0];
        A_OUT_VAL: out_val <= bus_wdata[N-1:0];
        A_OUT_XOR: out_xor <= bus_wdata[N-1:0];
        default: ;
      endcase
      for (int k = 0; k < N_EV; k++)
        if (bus_addr == ev_en_addr(k)) ev_en[k] <= bus_wdata[N-1:0];
    end
  end

  always_comb begin
    for (int k = 0; k < N_EV; k++)
      clr[k] = (bus_wr && bus_addr == ev_pend_addr(k)) ? bus_wdata[N-1:0] : '0;
  end

  gpio_in_sync #(.N(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .en(in_en), .level(level)
  );

  gpio_event_unit #(.N(N)) u_ev (
    .clk(clk), .rst_n(rst_n), .level(level), .in_en(in_en), .ev_en(ev_en),
    .clr(clr), .pend(pend), .hit(hit), .level_q(level_q), .irq(pin_irq)
  );

  for (genvar p = 0; p < N; p++) begin : g_drv
    assign pin_out[p] = drive_bit(out_val[p], out_xor[p]);
  end
  assign pin_oe = out_en;

  always_comb begin
    rd_n = '0;
    case (bus_addr)
      A_IN_VAL:  rd_n = level;
      A_IN_EN:   rd_n = in_en;
      A_OUT_EN:  rd_n = out_en;
      A_OUT_VAL: rd_n = out_val;
      A_OUT_XOR: rd_n = out_xor;
      default: ;
    endcase
    for (int k = 0; k < N_EV; k++) begin
      if (bus_addr == ev_en_addr(k))   rd_n = ev_en[k];
      if (bus_addr == ev_pend_addr(k)) rd_n = pend[k];
    end
    bus_rdata = '0;
    bus_rdata[N-1:0] = rd_n;
  end

  // R7: no condition is detected on a pin whose sampling is off
  assert_ien_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit[EV_RISE] | hit[EV_FALL] | hit[EV_HIGH] | hit[EV_LOW]) & ~in_en) == '0);

  // R2: the pins only change after a register write
  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> ($stable(pin_out) && $stable(pin_oe)));

  // R6: with every enable clear, no pin interrupts
  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_en == '0) |-> (pin_irq == '0));
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int CLK_P = 10;
  localparam logic [6:0] IN_VAL = 7'h00, IN_EN = 7'h04, OUT_EN = 7'h08, OUT_VAL = 7'h0C,
                         OUT_XOR = 7'h40, RISE_EN = 7'h18, RISE_PD = 7'h1C, FALL_EN = 7'h20,
                         FALL_PD = 7'h24, HIGH_PD = 7'h2C, LOW_EN = 7'h30, LOW_PD = 7'h34;

  // {out_val, out_xor, expected pin_out, input enable, pin levels, expected input value}
  localparam logic [191:0] VEC [4] = '{
    {32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 32'hFFFF0000, 32'h12345678, 32'h12340000},
    {32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 32'h0000FFFF, 32'hFFFFFFFF, 32'h0000FFFF},
    {32'h12345678, 32'hFFFFFFFF, 32'hEDCBA987, 32'h00000000, 32'hFFFFFFFF, 32'h00000000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pin_irq;
  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #(CLK_P / 2) clk = ~clk;

  gpio_irq_ctrl #(.N_PINS(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_irq(pin_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(IN_VAL, rv);  chk("R1 input value", rv, 32'h0);
    rd(RISE_PD, rv); chk("R1 rise pending", rv, 32'h0);
    rd(OUT_VAL, rv); chk("R1 output value", rv, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_irq", pin_irq, 32'h0);

    for (int i = 0; i < 4; i++) begin
      wr(OUT_VAL, VEC[i][191:160]);
      wr(OUT_XOR, VEC[i][159:128]);
      wr(OUT_EN, VEC[i][159:128]);
      wr(IN_EN, VEC[i][95:64]);
      set_pins(VEC[i][63:32]);
      chk("R2 pin_out", pin_out, VEC[i][127:96]);
      chk("R2 pin_oe", pin_oe, VEC[i][159:128]);
      rd(OUT_VAL, rv); chk("R3 output readback", rv, VEC[i][191:160]);
      rd(IN_VAL, rv);  chk("R4 input value", rv, VEC[i][31:0]);
    end

    // all pins low, sampling on, pendings cleared
    wr(IN_EN, 32'hFFFFFFFF);
    set_pins(32'h0);
    wr(RISE_PD, 32'hFFFFFFFF);
    wr(FALL_PD, 32'hFFFFFFFF);
    wr(HIGH_PD, 32'hFFFFFFFF);
    wr(LOW_PD, 32'hFFFFFFFF);
    // R11: low level hits on the same cycle as the clear
    rd(LOW_PD, rv);  chk("R11 low pending survives clear", rv, 32'hFFFFFFFF);
    rd(RISE_PD, rv); chk("R10 rise pending cleared", rv, 32'h0);

    // R5 rise on pins 3 and 5, rise enabled for pin 3 only
    wr(RISE_EN, 32'h8);
    set_pins(32'h28);
    rd(RISE_PD, rv); chk("R5 rise pending", rv, 32'h28);
    rd(HIGH_PD, rv); chk("R5 high pending", rv, 32'h28);
    chk("R6 irq pin 3 only", pin_irq, 32'h8);

    // R10 clear only bit 3, then a zero write
    wr(RISE_PD, 32'h8);
    rd(RISE_PD, rv); chk("R10 selective clear", rv, 32'h20);
    wr(RISE_PD, 32'h0);
    rd(RISE_PD, rv); chk("R10 zero write keeps", rv, 32'h20);
    chk("R6 irq gone after clear", pin_irq, 32'h0);

    // R9 sticky after pins drop, R8 fall set with fall disabled
    set_pins(32'h0);
    rd(RISE_PD, rv); chk("R9 rise pending sticky", rv, 32'h20);
    rd(FALL_PD, rv); chk("R8 fall pending while disabled", rv, 32'h28);
    chk("R8 no irq from disabled", pin_irq, 32'h0);

    // R6 separate lines: low on pin 0, fall on pin 5
    wr(LOW_EN, 32'h1);
    wr(FALL_EN, 32'h20);
    chk("R6 per-pin lines", pin_irq, 32'h21);
    wr(LOW_EN, 32'h0);
    wr(FALL_EN, 32'h0);
    wr(RISE_EN, 32'h0);
    chk("R6 all disabled", pin_irq, 32'h0);

    // R7 sampling off for pin 7
    wr(IN_EN, 32'hFFFFFF7F);
    wr(RISE_PD, 32'hFFFFFFFF);
    set_pins(32'h80);
    rd(RISE_PD, rv); chk("R7 no rise on unsampled pin", rv, 32'h0);
    rd(IN_VAL, rv);  chk("R7 input value masked", rv, 32'h0);

    // R10 clear wins once the level has gone
    wr(HIGH_PD, 32'h8);
    rd(HIGH_PD, rv); chk("R10 high pending cleared", rv, 32'h20);

    finish_run();
  end
endmodule